// File: doc/BRIEF.md
# SPI Peripheral Interrupt and Soft-Reset Front End

This block sits beside a serial-peripheral-interface core on a shared register bus and turns the core's event pulses into one level-sensitive interrupt line. Each single-cycle event pulse sets a sticky status bit. A per-source mask selects which status bits take part. A single global enable bit gates the masked result onto the interrupt output. Software reads the status word and writes the same value back to acknowledge the events it has handled.

The same front end also holds a keyed soft-reset register. Writing the key value holds the attached core's reset output high for a fixed number of clock cycles. For that whole window it keeps the status and per-source enable registers clear. Writes of any other value to that register are dropped.

Register offsets (byte addresses on an 8-bit address bus): global enable 0x1C, status 0x20, per-source enable 0x28, soft reset 0x40. Reads are combinational from the presented address.

Top module: `spi_irq_frontend`

## Requirements
- R1: After the hardware reset `rst_n` is released, `irq_o` and `core_rst_o` are 0, and reads of the global enable (0x1C), status (0x20) and per-source enable (0x28) registers all return 0.
- R2: A one-cycle pulse on `evt_i[k]` sets status bit k, which reads back at 0x20 from the next cycle on and stays set until it is cleared. The bit order is: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive FIFO full, 5 receive overrun, 6 transmit FIFO half empty.
- R3: A write to the status register clears exactly the status bits whose written data bit is 1. Status bits written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The per-source enable register at 0x28 stores data bits 6..0. Its bits 31..7 read 0.
- R6: The global enable register at 0x1C stores only data bit 31. All other bits read 0.
- R7: `irq_o` is 1 exactly when the global enable is 1 and at least one status bit is set whose per-source enable bit is also 1.
- R8: A write of 0x0000000A to 0x40 raises `core_rst_o` in the next cycle and holds it high for exactly 16 cycles.
- R9: A write of any value other than 0x0000000A to 0x40 leaves `core_rst_o` low and leaves the status and enable registers unchanged.
- R10: A soft reset clears the status and per-source enable registers. While `core_rst_o` is high, event pulses and enable writes have no effect. The global enable keeps its value.
- R11: Reads of the soft-reset offset and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| evt_i | input | 7 | Event pulses from the SPI core, one bit per source |
| irq_o | output | 1 | Level interrupt output |
| core_rst_o | output | 1 | Soft-reset output to the attached core and its FIFOs |

## Verification
The bench fires an event on a status bit in the same cycle as a write-one clear of that bit. A design that gives priority to the clear would lose the event and read the bit as 0. It acknowledges one bit while another stays set; a design that cleared the whole word on any write would lose the second event. It writes near-miss key values, which a design that decodes only some data bits would take as a reset. It counts the soft-reset window cycle by cycle, so an off-by-one counter shows as 15 or 17 cycles. During the window it injects events and enable writes, which a design that does not hold the registers clear would let through. It also toggles the global enable while a masked event is pending, to catch a gate wired in the wrong place.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned NUM_SRC    = 7;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned GIE_BIT    = 31;
    localparam int unsigned RST_CYCLES = 16;

    localparam logic [ADDR_W-1:0] OFF_GIE    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_SRST   = 8'h40;

    localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;

    // Status / enable bit positions (order is seen by software)
    typedef enum int unsigned {
        SRC_MODE_FAULT   = 0,
        SRC_SLAVE_FAULT  = 1,
        SRC_TX_EMPTY     = 2,
        SRC_TX_UNDERRUN  = 3,
        SRC_RX_FULL      = 4,
        SRC_RX_OVERRUN   = 5,
        SRC_TX_HALF      = 6
    } irq_src_e;

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         ack_wr_i,
    input  logic [N-1:0] ack_mask_i,
    input  logic         flush_i,
    output logic [N-1:0] status_o
);

    typedef struct packed {
        logic [N-1:0] bits;
    } bank_t;

    bank_t bank_d, bank_q;

    // One sticky cell per source: flush > set > acknowledge
    for (genvar k = 0; k < N; k++) begin : g_cell
        always_comb begin
            bank_d.bits[k] = bank_q.bits[k];
            if (flush_i) begin
                bank_d.bits[k] = 1'b0;
            end else if (evt_i[k]) begin
                bank_d.bits[k] = 1'b1;
            end else if (ack_wr_i && ack_mask_i[k]) begin
                bank_d.bits[k] = 1'b0;
            end
        end

        // R2: a pulse outside a flush leaves its bit set
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_i[k] && !flush_i) |=> status_o[k]);

        // R3: acknowledge without a competing event clears the bit
        a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr_i && ack_mask_i[k] && !evt_i[k]) |=> !status_o[k]);

        // R3: a bit not acknowledged, not flushed and not hit holds
        a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush_i && !evt_i[k] && !(ack_wr_i && ack_mask_i[k])) |=>
            (status_o[k] == $past(status_o[k])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_o = bank_q.bits;

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
    parameter int unsigned N       = 7,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GIE_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mask_wr_i,
    input  logic              gie_wr_i,
    input  logic              flush_i,
    output logic [N-1:0]      mask_o,
    output logic              gie_o
);

    typedef struct packed {
        logic [N-1:0] mask;
        logic         gie;
    } en_t;

    en_t en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (flush_i) begin
            en_d.mask = '0;
        end else if (mask_wr_i) begin
            en_d.mask = wdata_i[N-1:0];
        end
        if (gie_wr_i) begin
            en_d.gie = wdata_i[GIE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign mask_o = en_q.mask;
    assign gie_o  = en_q.gie;

    // R10: a flush empties the mask
    a_r10_flush_mask: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (mask_o == '0));

    // R10: global enable only moves on its own write
    a_r10_gie_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_wr_i |=> $stable(gie_o));

endmodule

// File: rtl/soft_reset_gen.sv
module soft_reset_gen #(
    parameter int unsigned           DATA_W = 32,
    parameter logic [DATA_W-1:0]     KEY    = 32'h0000_000A,
    parameter int unsigned           CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              flush_o,
    output logic              core_rst_o
);

    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } srst_t;

    srst_t sr_d, sr_q;
    logic  key_accept;

    // A key hit while the window runs is dropped
    assign key_accept = wr_i && (wdata_i == KEY) && !sr_q.active;

    always_comb begin
        sr_d = sr_q;
        if (sr_q.active) begin
            if (sr_q.cnt == '0) begin
                sr_d.active = 1'b0;
            end else begin
                sr_d.cnt = sr_q.cnt - 1'b1;
            end
        end else if (key_accept) begin
            sr_d.active = 1'b1;
            sr_d.cnt    = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign core_rst_o = sr_q.active;
    assign flush_o    = key_accept || sr_q.active;

    // Window length checker: counts high cycles of the reset output
    logic [CNT_W:0] run_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len_q <= '0;
        end else if (core_rst_o) begin
            run_len_q <= run_len_q + 1'b1;
        end else begin
            run_len_q <= '0;
        end
    end

    // R8: key accepted -> reset output high next cycle
    a_r8_key_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (wdata_i == KEY) && !core_rst_o) |=> core_rst_o);

    // R8: the window lasts exactly CYCLES cycles
    a_r8_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> (run_len_q == (CNT_W+1)'(CYCLES)));

    // R9: a non-key value never starts a window
    a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_rst_o && !(wr_i && (wdata_i == KEY))) |=> !core_rst_o);

endmodule

// File: rtl/spi_irq_frontend.sv
module spi_irq_frontend
    import spi_irq_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC,
    parameter int unsigned AW    = ADDR_W,
    parameter int unsigned DW    = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    output logic [DW-1:0] bus_rdata_o,
    input  logic [N_SRC-1:0] evt_i,
    output logic          irq_o,
    output logic          core_rst_o
);

    logic             wr_gie, wr_status, wr_mask, wr_srst;
    logic             flush;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] mask;
    logic             gie;

    // Write decode
    always_comb begin
        wr_gie    = bus_wr_i && (bus_addr_i == AW'(OFF_GIE));
        wr_status = bus_wr_i && (bus_addr_i == AW'(OFF_STATUS));
        wr_mask   = bus_wr_i && (bus_addr_i == AW'(OFF_ENABLE));
        wr_srst   = bus_wr_i && (bus_addr_i == AW'(OFF_SRST));
    end

    soft_reset_gen #(
        .DATA_W (DW),
        .KEY    (DW'(SRST_KEY)),
        .CYCLES (RST_CYCLES)
    ) u_srst (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_srst),
        .wdata_i    (bus_wdata_i),
        .flush_o    (flush),
        .core_rst_o (core_rst_o)
    );

    irq_status_bank #(
        .N (N_SRC)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .ack_wr_i   (wr_status),
        .ack_mask_i (bus_wdata_i[N_SRC-1:0]),
        .flush_i    (flush),
        .status_o   (status)
    );

    irq_enable_regs #(
        .N       (N_SRC),
        .DATA_W  (DW),
        .GIE_BIT (GIE_BIT)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata_i   (bus_wdata_i),
        .mask_wr_i (wr_mask),
        .gie_wr_i  (wr_gie),
        .flush_i   (flush),
        .mask_o    (mask),
        .gie_o     (gie)
    );

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            AW'(OFF_GIE):    bus_rdata_o[GIE_BIT]   = gie;
            AW'(OFF_STATUS): bus_rdata_o[N_SRC-1:0] = status;
            AW'(OFF_ENABLE): bus_rdata_o[N_SRC-1:0] = mask;
            default:         bus_rdata_o            = '0;
        endcase
    end

    assign irq_o = gie && (|(status & mask));

    // R7: no interrupt without the global enable
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq_o);

    // R7: no interrupt while nothing is both pending and enabled
    a_r7_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == '0) |-> !irq_o);

    // R10: throughout the soft-reset window status and mask stay empty
    a_r10_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> ((status == '0) && (mask == '0)));

endmodule

// File: tb/tb_spi_irq_frontend.sv
module tb_spi_irq_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = 8'h00;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [6:0]  evt_i = '0;
    logic        irq_o;
    logic        core_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    spi_irq_frontend dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .evt_i       (evt_i),
        .irq_o       (irq_o),
        .core_rst_o  (core_rst_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Inputs change and outputs are sampled on the falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        @(negedge clk);
        rd(8'h1C, v); chk("R1 gie", v, 32'h0);
        rd(8'h20, v); chk("R1 status", v, 32'h0);
        rd(8'h28, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 core_rst", {31'b0, core_rst_o}, 32'h0);
        rd(8'h40, v); chk("R11 srst read", v, 32'h0);
        rd(8'h30, v); chk("R11 unmapped read", v, 32'h0);
    endtask

    task automatic t_event_set();
        logic [31:0] v;
        pulse(7'h05);
        rd(8'h20, v); chk("R2 mode+txempty set", v, 32'h05);
        repeat (5) @(negedge clk);
        rd(8'h20, v); chk("R2 sticky", v, 32'h05);
        pulse(7'h40);
        rd(8'h20, v); chk("R2 half-empty bit6", v, 32'h45);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(8'h20, 32'h04);
        rd(8'h20, v); chk("R3 clear bit2 only", v, 32'h41);
        wr(8'h20, 32'h41);
        rd(8'h20, v); chk("R3 write-back clears", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(7'h02);
        pulse(7'h08);
        @(negedge clk);
        bus_wr_i = 1'b1; bus_addr_i = 8'h20; bus_wdata_i = 32'h0A;
        evt_i = 7'h02;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0; evt_i = '0;
        rd(8'h20, v); chk("R4 set beats clear", v, 32'h02);
        wr(8'h20, 32'h02);
    endtask

    task automatic t_enable_regs();
        logic [31:0] v;
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R5 mask width", v, 32'h7F);
        wr(8'h28, 32'h0000_0015);
        rd(8'h28, v); chk("R5 mask value", v, 32'h15);
        wr(8'h1C, 32'h7FFF_FFFF);
        rd(8'h1C, v); chk("R6 gie only bit31 (0)", v, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, v); chk("R6 gie bit31", v, 32'h8000_0000);
        wr(8'h1C, 32'h0);
        wr(8'h28, 32'h0);
    endtask

    task automatic t_irq();
        wr(8'h28, 32'h10);
        wr(8'h1C, 32'h8000_0000);
        chk("R7 idle", {31'b0, irq_o}, 32'h0);
        pulse(7'h08);
        chk("R7 masked source", {31'b0, irq_o}, 32'h0);
        pulse(7'h10);
        chk("R7 enabled source", {31'b0, irq_o}, 32'h1);
        wr(8'h1C, 32'h0);
        chk("R7 gie off", {31'b0, irq_o}, 32'h0);
        wr(8'h1C, 32'h8000_0000);
        chk("R7 gie back on", {31'b0, irq_o}, 32'h1);
        wr(8'h20, 32'h10);
        chk("R7 acked", {31'b0, irq_o}, 32'h0);
        wr(8'h20, 32'h08);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        pulse(7'h01);
        wr(8'h28, 32'h01);
        wr(8'h40, 32'h0000_000B);
        chk("R9 0x0B", {31'b0, core_rst_o}, 32'h0);
        wr(8'h40, 32'h0000_010A);
        chk("R9 0x10A", {31'b0, core_rst_o}, 32'h0);
        wr(8'h40, 32'h8000_000A);
        chk("R9 0x8000000A", {31'b0, core_rst_o}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 still idle", {31'b0, core_rst_o}, 32'h0);
        rd(8'h20, v); chk("R9 status kept", v, 32'h01);
        rd(8'h28, v); chk("R9 mask kept", v, 32'h01);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        int high_cnt;
        // gie is 1 from t_irq; status bit0 and mask bit0 still set
        chk("R7 pre-reset irq", {31'b0, irq_o}, 32'h1);
        wr(8'h40, 32'h0000_000A);
        high_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (core_rst_o) high_cnt++;
            if (i < 16)
                chk("R8 window high", {31'b0, core_rst_o}, 32'h1);
            else
                chk("R8 window ended", {31'b0, core_rst_o}, 32'h0);
            // stimulus inside the window that must be ignored
            evt_i = (i == 3) ? 7'h7F : 7'h00;
            bus_wr_i    = (i == 6);
            bus_addr_i  = 8'h28;
            bus_wdata_i = (i == 6) ? 32'h7F : 32'h0;
            if (i == 10) begin
                rd(8'h20, v); chk("R10 status cleared in window", v, 32'h0);
            end
            @(negedge clk);
        end
        bus_wr_i = 1'b0; evt_i = '0;
        chk("R8 window length", high_cnt, 16);
        rd(8'h20, v); chk("R10 status after", v, 32'h0);
        rd(8'h28, v); chk("R10 mask after", v, 32'h0);
        rd(8'h1C, v); chk("R10 gie kept", v, 32'h8000_0000);
        chk("R10 irq low", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_event_set();
        t_ack();
        t_set_wins();
        t_enable_regs();
        t_irq();
        t_bad_key();
        t_soft_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule